// File: doc/BRIEF.md
# Bus Status Code Generator

This block drives a 3-bit status code that tells logic outside a bus-mastering network controller which memory region the controller's DMA engine is using. At the start of each bus tenure it latches the region named by the master sequencer and shows that region's code for the whole block transfer. The code is replaced by the idle code `111` in three cases: while a host register access is under way, and during two fixed-length gaps that the receive descriptor sequencer inserts between its field accesses. The filter-table region is the one exception to a fixed code: when the source-address write completes, its code steps from `010` to `011`.

A strap input selects the strobe convention. The block flags the cycle in which external logic should capture the code: after a falling address strobe in big-endian mode, and after a rising one in little-endian mode. Every result is registered on the bus clock, so each output reflects the inputs sampled at the previous rising edge.

The FSM has four states. `FS_OFF` means no tenure is held. `FS_XFER` shows the latched region code. `FS_REG` shows idle during a register access. `FS_GAP` shows idle while a descriptor gap is counting down. The transitions are:
- OFF→XFER when a tenure begins.
- Any→OFF when the tenure ends.
- XFER/GAP→REG when a register access starts.
- XFER/REG→GAP when a gap is owed and no access is active.
- REG/GAP→XFER when both have finished.

Top module: `bstat_gen`

## Requirements
- R1: Synchronous reset, active high, forces `bus_stat_o` to `111` and `stat_capt_o` to 0 from the first clock edge at which reset is sampled high.
- R2: In a cycle where `bus_own_i` is sampled low, `bus_stat_o` shows `111` after that edge.
- R3: The region is latched on the first owned cycle of a tenure. Changes on `area_sel_i` later in the same tenure have no effect on `bus_stat_o`.
- R4: Region select values map to codes as follows: 0 transmit descriptors→`000`, 1 transmit buffers→`001`, 2 receive descriptors→`100`, 3 receive buffers→`101`, 4 receive resources→`110`, 5 filter table→`010`. The select values 6 and 7 give `111`.
- R5: Each cycle in which `reg_acc_i` is sampled high during a tenure makes `bus_stat_o` show `111` after that edge. When the access ends, the latched code returns.
- R6: A `src_done_i` pulse while the latched code is `010` changes the latched code to `011` for the rest of the tenure. For any other latched code the pulse is ignored.
- R7: A `gap_long_i` pulse during a tenure gives exactly two idle (`111`) cycles before the latched code returns.
- R8: A `gap_short_i` pulse during a tenure gives exactly one idle cycle before the latched code returns.
- R9: When a register access and a gap overlap, `bus_stat_o` stays `111` until both the access has ended and the gap count has run out. It then returns to the latched code.
- R10: `stat_capt_o` pulses for one cycle after an edge of `addr_strb_i` is sampled. With `be_mode_i`=1 the edge is a falling one, with `be_mode_i`=0 a rising one. The opposite edge gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| be_mode_i | input | 1 | Strap: 1 big-endian, 0 little-endian |
| bus_own_i | input | 1 | Controller holds the bus (tenure active) |
| area_sel_i | input | 3 | Region selected by the master sequencer |
| reg_acc_i | input | 1 | Host register access in progress |
| src_done_i | input | 1 | Source-address write completed (pulse) |
| gap_long_i | input | 1 | Sequence-to-link descriptor gap marker (pulse) |
| gap_short_i | input | 1 | Link-to-in-use descriptor gap marker (pulse) |
| addr_strb_i | input | 1 | Address strobe level |
| bus_stat_o | output | 3 | Registered bus status code |
| stat_capt_o | output | 1 | Capture point for the status code |

## Verification
The bench targets several corner cases:
- **Region changes mid-tenure.** A design that tracked `area_sel_i` continuously would change the code inside a transfer.
- **Register access.** The access is held for several cycles and then released. A design without a saved code would resume with the wrong region.
- **Source-address event.** It is applied both to the filter region and to a transmit region. A careless design would step the transmit code.
- **Overlapping access and gap.** A register access is started together with each gap type and checked cycle by cycle. Dropping the gap count when the access ends would return to the region code one or two cycles early.
- **Strobe edges in both strap settings.** Swapping the edge polarity would put the capture pulse on the wrong edge.

// File: rtl/bstat_pkg.sv
package bstat_pkg;

    localparam int STAT_W = 3;
    localparam int SEL_W  = 3;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t CODE_IDLE      = 3'b111;
    localparam stat_t CODE_TX_DESC   = 3'b000;
    localparam stat_t CODE_TX_BUF    = 3'b001;
    localparam stat_t CODE_RX_DESC   = 3'b100;
    localparam stat_t CODE_RX_BUF    = 3'b101;
    localparam stat_t CODE_RX_RES    = 3'b110;
    localparam stat_t CODE_FILT      = 3'b010;
    localparam stat_t CODE_FILT_DONE = 3'b011;

    typedef enum logic [SEL_W-1:0] {
        AREA_TX_DESC = 3'd0,
        AREA_TX_BUF  = 3'd1,
        AREA_RX_DESC = 3'd2,
        AREA_RX_BUF  = 3'd3,
        AREA_RX_RES  = 3'd4,
        AREA_FILT    = 3'd5
    } area_t;

    typedef enum logic [1:0] {
        FS_OFF  = 2'd0,
        FS_XFER = 2'd1,
        FS_REG  = 2'd2,
        FS_GAP  = 2'd3
    } fsm_t;

endpackage

// File: rtl/bstat_area_map.sv
module bstat_area_map
    import bstat_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output stat_t            code_o
);

    always_comb begin
        case (sel_i)
            AREA_TX_DESC: code_o = CODE_TX_DESC;
            AREA_TX_BUF:  code_o = CODE_TX_BUF;
            AREA_RX_DESC: code_o = CODE_RX_DESC;
            AREA_RX_BUF:  code_o = CODE_RX_BUF;
            AREA_RX_RES:  code_o = CODE_RX_RES;
            AREA_FILT:    code_o = CODE_FILT;
            default:      code_o = CODE_IDLE;
        endcase
    end

endmodule

// File: rtl/bstat_gap_timer.sv
module bstat_gap_timer #(
    parameter int LONG_GAP  = 2,
    parameter int SHORT_GAP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic long_i,
    input  logic short_i,
    output logic pend_o
);

    localparam int MAX_GAP = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
    localparam int CW      = $clog2(MAX_GAP + 1);

    logic [CW-1:0] rem_q;
    logic [CW-1:0] rem_dec;
    logic [CW-1:0] rem_load;
    logic [CW-1:0] rem_n;

    always_comb begin
        rem_dec  = (rem_q == '0) ? '0 : rem_q - 1'b1;
        if (long_i)
            rem_load = CW'(LONG_GAP);
        else if (short_i)
            rem_load = CW'(SHORT_GAP);
        else
            rem_load = '0;
        if (clr_i)
            rem_n = '0;
        else if (rem_load > rem_dec)
            rem_n = rem_load;
        else
            rem_n = rem_dec;
    end

    assign pend_o = (rem_n != '0);

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else
            rem_q <= rem_n;
    end

endmodule

// File: rtl/bstat_strobe_qual.sv
module bstat_strobe_qual (
    input  logic clk,
    input  logic rst,
    input  logic be_mode_i,
    input  logic strb_i,
    output logic capt_o
);

    logic strb_q;
    logic edge_hit;

    always_ff @(posedge clk) begin
        strb_q <= strb_i;
    end

    always_comb begin
        if (be_mode_i)
            edge_hit = strb_q & ~strb_i;
        else
            edge_hit = ~strb_q & strb_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            capt_o <= 1'b0;
        else
            capt_o <= edge_hit;
    end

endmodule

// File: rtl/bstat_gen.sv
module bstat_gen
    import bstat_pkg::*;
#(
    parameter int LONG_GAP  = 2,
    parameter int SHORT_GAP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             be_mode_i,
    input  logic             bus_own_i,
    input  logic [SEL_W-1:0] area_sel_i,
    input  logic             reg_acc_i,
    input  logic             src_done_i,
    input  logic             gap_long_i,
    input  logic             gap_short_i,
    input  logic             addr_strb_i,
    output logic [STAT_W-1:0] bus_stat_o,
    output logic             stat_capt_o
);

    fsm_t  state_q, state_n;
    stat_t save_q, save_n;
    stat_t sel_code;
    logic  gap_pend;

    bstat_area_map u_map (
        .sel_i  (area_sel_i),
        .code_o (sel_code)
    );

    bstat_gap_timer #(
        .LONG_GAP  (LONG_GAP),
        .SHORT_GAP (SHORT_GAP)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (~bus_own_i),
        .long_i  (gap_long_i),
        .short_i (gap_short_i),
        .pend_o  (gap_pend)
    );

    bstat_strobe_qual u_strb (
        .clk       (clk),
        .rst       (rst),
        .be_mode_i (be_mode_i),
        .strb_i    (addr_strb_i),
        .capt_o    (stat_capt_o)
    );

    // Next-state and latched-code logic
    always_comb begin
        state_n = state_q;
        save_n  = save_q;
        unique case (state_q)
            FS_OFF: begin
                if (bus_own_i) begin
                    save_n = sel_code;
                    if (reg_acc_i)
                        state_n = FS_REG;
                    else if (gap_pend)
                        state_n = FS_GAP;
                    else
                        state_n = FS_XFER;
                end
            end
            FS_XFER, FS_REG, FS_GAP: begin
                if (!bus_own_i)
                    state_n = FS_OFF;
                else if (reg_acc_i)
                    state_n = FS_REG;
                else if (gap_pend)
                    state_n = FS_GAP;
                else
                    state_n = FS_XFER;
                if (bus_own_i && src_done_i && save_q == CODE_FILT)
                    save_n = CODE_FILT_DONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_OFF;
            save_q  <= CODE_IDLE;
        end else begin
            state_q <= state_n;
            save_q  <= save_n;
        end
    end

    // Registered status output
    always_ff @(posedge clk) begin
        if (rst)
            bus_stat_o <= CODE_IDLE;
        else if (state_n == FS_XFER)
            bus_stat_o <= save_n;
        else
            bus_stat_o <= CODE_IDLE;
    end

endmodule

// File: rtl/bstat_chk.sv
module bstat_chk (
    input logic       clk,
    input logic       rst,
    input logic       be_mode_i,
    input logic       bus_own_i,
    input logic       reg_acc_i,
    input logic       src_done_i,
    input logic       gap_long_i,
    input logic       gap_short_i,
    input logic       addr_strb_i,
    input logic [2:0] bus_stat_o,
    input logic       stat_capt_o
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (bus_stat_o == 3'b111 && !stat_capt_o)); // R1
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst) !bus_own_i |=> bus_stat_o == 3'b111); // R2
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst) (bus_own_i && bus_stat_o != 3'b111 && !reg_acc_i && !gap_long_i && !gap_short_i && !src_done_i) |=> $stable(bus_stat_o)); // R3
    AST_REG_IDLE: assert property (@(posedge clk) disable iff (rst) (bus_own_i && reg_acc_i) |=> bus_stat_o == 3'b111); // R5
    AST_FILT_STEP: assert property (@(posedge clk) disable iff (rst) (bus_own_i && bus_stat_o == 3'b010 && src_done_i && !reg_acc_i && !gap_long_i && !gap_short_i) |=> bus_stat_o == 3'b011); // R6
    AST_LONG_GAP: assert property (@(posedge clk) disable iff (rst) (bus_own_i && gap_long_i) ##1 bus_own_i |=> bus_stat_o == 3'b111); // R7
    AST_SHORT_GAP: assert property (@(posedge clk) disable iff (rst) (bus_own_i && gap_short_i) |=> bus_stat_o == 3'b111); // R8
    AST_CAPT_FALL: assert property (@(posedge clk) disable iff (rst) (be_mode_i && $fell(addr_strb_i)) |=> stat_capt_o); // R10
    AST_CAPT_RISE: assert property (@(posedge clk) disable iff (rst) (!be_mode_i && $rose(addr_strb_i)) |=> stat_capt_o); // R10

endmodule

bind bstat_gen bstat_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .be_mode_i   (be_mode_i),
    .bus_own_i   (bus_own_i),
    .reg_acc_i   (reg_acc_i),
    .src_done_i  (src_done_i),
    .gap_long_i  (gap_long_i),
    .gap_short_i (gap_short_i),
    .addr_strb_i (addr_strb_i),
    .bus_stat_o  (bus_stat_o),
    .stat_capt_o (stat_capt_o)
);

// File: tb/sim_bstat_gen.sv
module sim_bstat_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       be_mode_i = 1'b0;
    logic       bus_own_i = 1'b0;
    logic [2:0] area_sel_i = 3'd0;
    logic       reg_acc_i = 1'b0;
    logic       src_done_i = 1'b0;
    logic       gap_long_i = 1'b0;
    logic       gap_short_i = 1'b0;
    logic       addr_strb_i = 1'b0;
    logic [2:0] bus_stat_o;
    logic       stat_capt_o;

    // staged stimulus, copied to the DUT at the falling edge
    logic       s_rst = 1'b1, s_be = 1'b0, s_own = 1'b0, s_reg = 1'b0;
    logic       s_src = 1'b0, s_g2 = 1'b0, s_g1 = 1'b0, s_strb = 1'b0;
    logic [2:0] s_area = 3'd0;

    typedef struct {
        logic [2:0] stat;
        logic       capt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    bstat_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .be_mode_i   (be_mode_i),
        .bus_own_i   (bus_own_i),
        .area_sel_i  (area_sel_i),
        .reg_acc_i   (reg_acc_i),
        .src_done_i  (src_done_i),
        .gap_long_i  (gap_long_i),
        .gap_short_i (gap_short_i),
        .addr_strb_i (addr_strb_i),
        .bus_stat_o  (bus_stat_o),
        .stat_capt_o (stat_capt_o)
    );

    // Driver: apply staged inputs for one cycle, push expected result
    task automatic tick(input logic [2:0] es, input logic ec, input string tag);
        exp_t e;
        @(negedge clk);
        rst         = s_rst;
        be_mode_i   = s_be;
        bus_own_i   = s_own;
        area_sel_i  = s_area;
        reg_acc_i   = s_reg;
        src_done_i  = s_src;
        gap_long_i  = s_g2;
        gap_short_i = s_g1;
        addr_strb_i = s_strb;
        e.stat = es;
        e.capt = ec;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (bus_stat_o !== e.stat || stat_capt_o !== e.capt) begin
                    n_bad++;
                    $display("FAIL %s: stat=%b capt=%b expected stat=%b capt=%b",
                             e.tag, bus_stat_o, stat_capt_o, e.stat, e.capt);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] codes [6];
        codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b100;
        codes[3] = 3'b101; codes[4] = 3'b110; codes[5] = 3'b010;

        // R1 reset
        s_rst = 1'b1;
        tick(3'b111, 1'b0, "R1 reset");
        tick(3'b111, 1'b0, "R1 reset");
        s_rst = 1'b0;
        // R2 no tenure
        tick(3'b111, 1'b0, "R2 idle off");
        tick(3'b111, 1'b0, "R2 idle off");

        // R3 latched region, select changes ignored
        s_own = 1'b1; s_area = 3'd0;
        tick(3'b000, 1'b0, "R4 tx desc");
        s_area = 3'd3;
        tick(3'b000, 1'b0, "R3 hold");
        s_area = 3'd5;
        tick(3'b000, 1'b0, "R3 hold");
        s_own = 1'b0;
        tick(3'b111, 1'b0, "R2 tenure end");

        // R4 each region
        for (int k = 1; k < 6; k++) begin
            s_own = 1'b1; s_area = 3'(k);
            tick(codes[k], 1'b0, "R4 region code");
            s_own = 1'b0;
            tick(3'b111, 1'b0, "R2 between tenures");
        end
        s_own = 1'b1; s_area = 3'd6;
        tick(3'b111, 1'b0, "R4 unused select");
        s_own = 1'b0;
        tick(3'b111, 1'b0, "R2 off");

        // R5 register access
        s_own = 1'b1; s_area = 3'd3;
        tick(3'b101, 1'b0, "R4 rx buf");
        s_reg = 1'b1;
        for (int k = 0; k < 3; k++) tick(3'b111, 1'b0, "R5 reg access idle");
        s_reg = 1'b0;
        tick(3'b101, 1'b0, "R5 restore");
        tick(3'b101, 1'b0, "R5 restore");
        s_own = 1'b0;
        tick(3'b111, 1'b0, "R2 off");

        // R6 source address step
        s_own = 1'b1; s_area = 3'd5;
        tick(3'b010, 1'b0, "R4 filter");
        s_src = 1'b1;
        tick(3'b011, 1'b0, "R6 step");
        s_src = 1'b0;
        tick(3'b011, 1'b0, "R6 held");
        s_reg = 1'b1;
        tick(3'b111, 1'b0, "R5 reg idle");
        s_reg = 1'b0;
        tick(3'b011, 1'b0, "R6 restored stepped code");
        s_own = 1'b0;
        tick(3'b111, 1'b0, "R2 off");
        s_own = 1'b1; s_area = 3'd1;
        tick(3'b001, 1'b0, "R4 tx buf");
        s_src = 1'b1;
        tick(3'b001, 1'b0, "R6 ignored");
        s_src = 1'b0;
        tick(3'b001, 1'b0, "R6 ignored");
        s_own = 1'b0;
        tick(3'b111, 1'b0, "R2 off");

        // R7 / R8 gaps
        s_own = 1'b1; s_area = 3'd2;
        tick(3'b100, 1'b0, "R4 rx desc");
        s_g2 = 1'b1;
        tick(3'b111, 1'b0, "R7 gap 1st");
        s_g2 = 1'b0;
        tick(3'b111, 1'b0, "R7 gap 2nd");
        tick(3'b100, 1'b0, "R7 restore");
        s_g1 = 1'b1;
        tick(3'b111, 1'b0, "R8 gap");
        s_g1 = 1'b0;
        tick(3'b100, 1'b0, "R8 restore");

        // R9 overlap
        s_reg = 1'b1; s_g2 = 1'b1;
        tick(3'b111, 1'b0, "R9 reg+long");
        s_reg = 1'b0; s_g2 = 1'b0;
        tick(3'b111, 1'b0, "R9 gap still owed");
        tick(3'b100, 1'b0, "R9 restore");
        s_reg = 1'b1; s_g1 = 1'b1;
        tick(3'b111, 1'b0, "R9 reg+short");
        s_g1 = 1'b0;
        tick(3'b111, 1'b0, "R9 reg continues");
        tick(3'b111, 1'b0, "R9 reg continues");
        s_reg = 1'b0;
        tick(3'b100, 1'b0, "R9 restore");
        s_own = 1'b0;
        tick(3'b111, 1'b0, "R2 off");

        // R10 strobe capture
        s_be = 1'b1; s_strb = 1'b1;
        tick(3'b111, 1'b0, "R10 big rise ignored");
        s_strb = 1'b0;
        tick(3'b111, 1'b1, "R10 big fall");
        tick(3'b111, 1'b0, "R10 single pulse");
        s_be = 1'b0; s_strb = 1'b1;
        tick(3'b111, 1'b1, "R10 little rise");
        tick(3'b111, 1'b0, "R10 single pulse");
        s_strb = 1'b0;
        tick(3'b111, 1'b0, "R10 little fall ignored");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule